// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Factory-Test Overrides

This block produces one left-aligned PWM waveform. A power-of-two prescaler feeds a down-counting scale counter. Each time the scale counter wraps, it advances an 8-bit channel counter. The channel counter returns to zero when it matches the period value. The output is high while the counter is below the duty value. All configuration goes through a small register bus: an address, write data, a write strobe, and combinational read data.

A test register holds override bits that alter the normal counter rules for factory test:

- keep the channel counter when it is written;
- ignore the period match;
- skip the scale-counter load on a scale-register write;
- freeze the whole count chain while a background-debug input is high.

The test register also stores two port settings, reduced drive and pull-up enable. These are only stored and read back; they have no effect on the block.

The test register accepts writes only while the active-low special-mode input is low. While that input is high, the register is cleared and held at zero.

Top module: `pwm_tst_chan`

## Requirements
- R1: After reset every register reads 0 and `pwm_out` is 0.
- R2: Register map, all readable:
  - address 0 is control: bit0 enable, bit1 scale select (0 = scale A, 1 = scale B), bits 4:2 prescale exponent.
  - address 1 is scale A and address 2 is scale B.
  - address 3 is the channel counter, address 4 is the period and address 5 is the duty.
  - address 7 is the test register: bit7 keep-counter-on-write, bit6 ignore-period-match, bit5 no-scale-load, bit4 background-freeze, bit3 reduced drive, bit2 pull-up.
  - all other addresses read 0.
- R3: A write to address 7 takes effect only while `mode_n` is 0. From the first clock edge with `mode_n` high, the test register reads 0.
- R4: While enabled, a prescaled tick occurs every 2^p clocks, where p is the prescale exponent. The first tick falls on the 2^p-th clock after enable. Clearing the enable resets the prescaler.
- R5: The scale counter delivers one channel tick every S prescaled ticks, where S is the selected scale register. A scale value of 0 means 256.
- R6: The channel counter increments on each channel tick. On a tick where the counter equals the period, it returns to 0 instead.
- R7: `pwm_out` is 1 exactly when the block is enabled and the channel counter is below the duty value.
- R8: A write to address 3 clears the channel counter when test bit7 is 0. When bit7 is 1, the write leaves the counter unchanged.
- R9: With test bit6 set, the period match is ignored and the counter wraps from 255 to 0.
- R10: A write to a scale register also loads the scale counter with the written value when test bit5 is 0. When bit5 is 1, only the register is updated.
- R11: With test bit4 set and `bg_dbg` high, the prescaler, scale counter and channel counter hold. With bit4 clear, `bg_dbg` has no effect.
- R12: Test bits 3 and 2 are stored and read back, with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rdata | output | 8 | Read data for `addr` |
| mode_n | input | 1 | Special mode when 0 |
| bg_dbg | input | 1 | Background-debug active |
| pwm_out | output | 1 | PWM output |

## Verification
The bound checker tests these rules on every cycle:

- the test register locks out while `mode_n` is high;
- the channel counter only holds, steps by one or returns to zero;
- the counter clears or is kept on a write, depending on the override bit;
- the counter returns to zero on a period match, or steps past the period when the override is set;
- the scale counter holds on a scale write when the load is disabled;
- the chain freezes under background debug.

Only the bench scenarios can show the waveform timing itself. That covers the period and duty cycle for several prescale and scale settings, the 256-step treatment of a zero scale value, the choice between the two scale registers, the offset phase left by a suppressed scale load, and register read-back.

// File: rtl/pwm_tst_chan.sv
module pwm_tst_chan #(
  parameter int CW  = 8,
  parameter int PSW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  input  logic          wr,
  output logic [CW-1:0] rdata,
  input  logic          mode_n,
  input  logic          bg_dbg,
  output logic          pwm_out
);
  localparam int PREW = (1 << PSW) - 1;
  localparam int SCW  = CW + 1;

  logic           en_q, sel_q;
  logic [PSW-1:0] ps_q;
  logic [CW-1:0]  scl_a, scl_b, cnt_q, per_q, duty_q;
  logic [5:0]     tst_q;
  logic [PREW-1:0] pre_q;
  logic [SCW-1:0] sc_q;

  wire keep_cnt = tst_q[5];
  wire no_match = tst_q[4];
  wire no_sload = tst_q[3];
  wire bg_stop  = tst_q[2];

  wire run = en_q && !(bg_stop && bg_dbg);
  wire [PREW:0]   one_sh = (PREW+1)'(1) << ps_q;
  wire [PREW-1:0] pmask  = PREW'(one_sh - 1'b1);
  wire ptick = run && ((pre_q & pmask) == pmask);
  wire stick = ptick && (sc_q <= SCW'(1));
  wire [CW-1:0] sel_scl = sel_q ? scl_b : scl_a;
  wire wr_cnt = wr && (addr == 3'd3);
  wire wr_scl = wr && (addr == 3'd1 || addr == 3'd2);
  wire match  = (cnt_q == per_q) && !no_match;

  function automatic logic [SCW-1:0] reload(input logic [CW-1:0] v);
    return (v == '0) ? (SCW'(1) << CW) : {1'b0, v};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; sel_q <= 1'b0; ps_q <= '0;
      scl_a <= '0; scl_b <= '0; per_q <= '0; duty_q <= '0;
      tst_q <= '0; pre_q <= '0; sc_q <= '0; cnt_q <= '0;
    end else begin
      if (wr) begin
        case (addr)
          3'd0: {ps_q, sel_q, en_q} <= wdata[PSW+1:0];
          3'd1: scl_a <= wdata;
          3'd2: scl_b <= wdata;
          3'd4: per_q <= wdata;
          3'd5: duty_q <= wdata;
          default: ;
        endcase
      end

      if (mode_n) tst_q <= '0;
      else if (wr && addr == 3'd7) tst_q <= wdata[7:2];

      if (!en_q) pre_q <= '0;
      else if (run) pre_q <= pre_q + 1'b1;

      if (wr_scl && !no_sload) sc_q <= reload(wdata);
      else if (ptick) sc_q <= (sc_q <= SCW'(1)) ? reload(sel_scl) : sc_q - 1'b1;

      if (wr_cnt) begin
        if (!keep_cnt) cnt_q <= '0;
      end else if (stick) begin
        cnt_q <= match ? '0 : cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0: rdata = CW'({ps_q, sel_q, en_q});
      3'd1: rdata = scl_a;
      3'd2: rdata = scl_b;
      3'd3: rdata = cnt_q;
      3'd4: rdata = per_q;
      3'd5: rdata = duty_q;
      3'd7: rdata = CW'({tst_q, 2'b00});
      default: rdata = '0;
    endcase
  end

  assign pwm_out = en_q && (cnt_q < duty_q);
endmodule

module pwm_tst_chan_chk #(
  parameter int CW  = 8,
  parameter int SCW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic [2:0]    addr,
  input logic          mode_n,
  input logic          bg_dbg,
  input logic          en_q,
  input logic [5:0]    tst_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] per_q,
  input logic [SCW-1:0] sc_q,
  input logic          stick
);
  p_test_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_n |=> (tst_q == '0));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 3'd3) |=> (cnt_q == $past(cnt_q) || cnt_q == CW'($past(cnt_q) + 1) || cnt_q == '0));

  p_period_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tst_q[4] && stick && cnt_q == per_q && !wr) |=> (cnt_q == '0));

  p_clear_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd3 && !tst_q[5]) |=> (cnt_q == '0));

  p_keep_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd3 && tst_q[5]) |=> $stable(cnt_q));

  p_ignore_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_q[4] && stick && !wr) |=> (cnt_q == CW'($past(cnt_q) + 1)));

  p_no_scale_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == 3'd1 || addr == 3'd2) && tst_q[3] && !en_q) |=> $stable(sc_q));

  p_bg_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_q[2] && bg_dbg && !wr) |=> ($stable(cnt_q) && $stable(sc_q)));
endmodule

bind pwm_tst_chan pwm_tst_chan_chk #(.CW(CW), .SCW(CW + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .mode_n(mode_n),
  .bg_dbg(bg_dbg), .en_q(en_q), .tst_q(tst_q), .cnt_q(cnt_q),
  .per_q(per_q), .sc_q(sc_q), .stick(stick)
);

// File: tb/pwm_tst_chan_test.sv
module pwm_tst_chan_test;
  logic clk = 0, rst_n = 0, wr = 0, mode_n = 1, bg_dbg = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  wire  [7:0] rdata;
  wire        pwm_out;

  always #2 clk = ~clk;

  pwm_tst_chan uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr),
    .rdata(rdata), .mode_n(mode_n), .bg_dbg(bg_dbg), .pwm_out(pwm_out)
  );

  typedef struct {int kind; int e1; int e2; string req;} item_t;
  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // kind 0: pwm_out, kind 1: rdata, kind 2: counter read-back and pwm_out
  always @(negedge clk) begin
    item_t it;
    if (q.size() != 0) begin
      it = q.pop_front();
      total++;
      case (it.kind)
        0: if (pwm_out !== it.e2[0]) begin
             bad++;
             $display("FAIL %s: out=%0b expected %0d", it.req, pwm_out, it.e2);
           end
        1: if (rdata !== it.e1[7:0]) begin
             bad++;
             $display("FAIL %s: rdata=%0d expected %0d", it.req, rdata, it.e1);
           end
        default: if (rdata !== it.e1[7:0] || pwm_out !== it.e2[0]) begin
             bad++;
             $display("FAIL %s: cnt=%0d out=%0b expected cnt=%0d out=%0d",
                      it.req, rdata, pwm_out, it.e1, it.e2);
           end
      endcase
    end
  end

  task automatic wreg(input int a, input int d);
    addr = 3'(a); wdata = 8'(d); wr = 1;
    @(posedge clk); #1; wr = 0;
  endtask

  task automatic rchk(input int a, input int e, input string r);
    addr = 3'(a);
    q.push_back('{1, e, 0, r});
    @(posedge clk); #1;
  endtask

  task automatic ochk(input int e, input string r);
    q.push_back('{0, 0, e, r});
    @(posedge clk); #1;
  endtask

  task automatic prep(input int sa, input int p, input int d);
    wreg(1, sa); wreg(3, 0); wreg(4, p); wreg(5, d);
  endtask

  // f: length of first channel tick in prescaled ticks, s: later ones (0 means 256 already applied)
  task automatic run(input int ps, input int sel, input int f, input int s, input int p,
                     input int d, input int nowrap, input int stop, input int bgon,
                     input int n, input string r);
    int m;
    m = 0;
    addr = 0; wdata = 8'((ps << 2) | (sel << 1) | 1); wr = 1;
    @(posedge clk); #1; wr = 0; addr = 3;
    for (int i = 0; i < n; i++) begin
      int t, k, c;
      bit g;
      t = m >> ps;
      k = (t < f) ? 0 : 1 + (t - f) / s;
      c = nowrap ? k % 256 : k % (p + 1);
      q.push_back('{2, c, (c < d) ? 1 : 0, r});
      g = (bgon != 0) && i >= 20 && i < 40;
      bg_dbg = g;
      @(posedge clk); #1;
      if (!(g && stop != 0)) m++;
    end
    bg_dbg = 0;
    wreg(0, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    rchk(0, 0, "R1 ctrl"); rchk(1, 0, "R1 scale A"); rchk(2, 0, "R1 scale B");
    rchk(3, 0, "R1 counter"); rchk(4, 0, "R1 period"); rchk(5, 0, "R1 duty");
    rchk(7, 0, "R1 test"); ochk(0, "R1 output");

    // R3 write protection, R12 pad bits
    mode_n = 1; wreg(7, 'hFC); rchk(7, 0, "R3 write ignored in normal mode");
    mode_n = 0; @(posedge clk); #1;
    wreg(7, 'h0C); rchk(7, 'h0C, "R12 pad bits read back");
    wreg(7, 'hF0); rchk(7, 'hF0, "R3 write in special mode");
    mode_n = 1; @(posedge clk); #1;
    rchk(7, 0, "R3 cleared in normal mode");

    // R2 register map
    wreg(0, 'h1E); rchk(0, 'h1E, "R2 ctrl"); wreg(0, 0);
    wreg(1, 'h5A); rchk(1, 'h5A, "R2 scale A");
    wreg(2, 'hA5); rchk(2, 'hA5, "R2 scale B");
    wreg(4, 'h33); rchk(4, 'h33, "R2 period");
    wreg(5, 'h44); rchk(5, 'h44, "R2 duty");
    rchk(6, 0, "R2 unused address");

    // R4 R5 R6 R7 waveforms
    prep(3, 4, 2);  run(0, 0, 3, 3, 4, 2, 0, 0, 0, 60, "R6 R7 period 4 duty 2");
    prep(1, 9, 7);  run(2, 0, 1, 1, 9, 7, 0, 0, 0, 100, "R4 prescale 4");
    prep(2, 5, 0);  run(0, 0, 2, 2, 5, 0, 0, 0, 0, 30, "R7 duty 0");
    prep(2, 5, 9);  run(0, 0, 2, 2, 5, 9, 0, 0, 0, 30, "R7 duty above period");
    prep(0, 255, 1); run(0, 0, 256, 256, 255, 1, 0, 0, 0, 600, "R5 scale 0 is 256");
    wreg(1, 7); wreg(2, 2); wreg(3, 0); wreg(4, 6); wreg(5, 3);
    run(0, 1, 2, 2, 6, 3, 0, 0, 0, 50, "R5 scale B selected");

    // R8 counter write
    prep(1, 200, 0); run(0, 0, 1, 1, 200, 0, 0, 0, 0, 10, "R6 short run");
    rchk(3, 11, "R6 count after run");
    mode_n = 0; @(posedge clk); #1;
    wreg(7, 'h80); wreg(3, 0); rchk(3, 11, "R8 write keeps counter");
    wreg(7, 0); wreg(3, 0); rchk(3, 0, "R8 write clears counter");

    // R9 period match ignored
    wreg(7, 'h40); prep(1, 3, 2);
    run(0, 0, 1, 1, 3, 2, 1, 0, 0, 300, "R9 wrap past period");

    // R10 scale load suppressed
    wreg(7, 0); wreg(1, 4); wreg(7, 'h20); wreg(1, 2);
    wreg(3, 0); wreg(4, 100); wreg(5, 3);
    run(0, 0, 4, 2, 100, 3, 0, 0, 0, 60, "R10 no scale load");
    rchk(1, 2, "R10 register still updated");

    // R11 background freeze
    wreg(7, 'h10); prep(1, 200, 10);
    run(0, 0, 1, 1, 200, 10, 0, 1, 1, 60, "R11 frozen under debug");
    wreg(7, 0); prep(1, 200, 10);
    run(0, 0, 1, 1, 200, 10, 0, 0, 1, 60, "R11 runs when bit clear");

    repeat (2) @(posedge clk);
    finish_up();
  end
endmodule